// File: doc/BRIEF.md
# USB Endpoint-Zero Control Sequencer

This block runs the control-transfer protocol for endpoint zero of a USB device. A lower packet layer has already decoded each transaction. It presents that transaction as a one-cycle event that carries the token kind, the received payload length and the data PID parity. The sequencer answers each event with a registered handshake decision: ACK, NAK, STALL, or no handshake. It follows the transfer through its setup, data and status stages, and it keeps track of whether the endpoint is currently transmitting.

Firmware drives the block through single-cycle pulses:

- marking a received packet as serviced;
- loading an outgoing packet together with its length;
- marking the final packet of a transfer;
- forcing a stall;
- clearing the sticky flags;
- acknowledging the interrupt.

The block enforces the protocol rules in hardware. It stalls on oversize packets, on tokens that arrive after the data stage has ended, and on non-empty status data. It flags a setup-end condition when the host cuts a transmit sequence short. The maximum packet size is a parameter, with a default of 64 bytes.

Top module: `usbEp0Seq`

## Requirements
- R1: After reset, every flag output, `irq`, `txMode` and `hsValid` is 0, and `phase` is 0 (idle).
- R2: A SETUP event (`evTok`=2'b10) is accepted only when `evLen`=8. An accepted SETUP produces `hsValid`=1 with `hsCode`=1 (ACK) one cycle later, sets `outPktRdy` and raises `irq`. Any other length produces no handshake and changes no flag.
- R3: `outPktRdy` stays set until a `fwServiced` pulse. An OUT event (`evTok`=2'b00) that arrives in the idle or OUT-data phase while `outPktRdy` is set gets NAK (`hsCode`=2).
- R4: An IN event (`evTok`=2'b01) in the idle or IN-data phase gets NAK and raises no interrupt when `inPktRdy` is clear. It gets ACK (data sent) when `inPktRdy` is set.
- R5: A `txAck` pulse after an IN packet has been sent clears `inPktRdy` and raises `irq`.
- R6: The first IN event of a transfer sets `txMode` and moves `phase` to 1 (IN data). The mode ends when an acknowledged packet's loaded length is below the maximum packet size (zero included). A full-size packet leaves the mode set.
- R7: A SETUP or OUT event that arrives while `txMode` is set sets `setupEnd` and clears `txMode`.
- R8: An IN packet loaded together with `fwDataEnd` moves `phase` to 3 (IN status) once it is acknowledged. A further IN event in that phase gets STALL (`hsCode`=3).
- R9: A `fwServiced` pulse that comes together with `fwDataEnd` moves `phase` to 4 (OUT status). An OUT event in that phase gets STALL.
- R10: An OUT event whose length exceeds the maximum packet size gets STALL. A length equal to the maximum is accepted.
- R11: In phase 3, an OUT event with DATA1 (`evData1`=1) and non-zero length gets STALL. A zero-length one gets ACK and returns `phase` to 0.
- R12: A `fwStall` pulse makes the next IN or OUT event get STALL. Every STALL sets `stallSent`, raises `irq` and returns `phase` to 0 with `txMode` clear.
- R13: `stallSent`, `setupEnd` and `irq` hold until their own clear pulse (`fwClrStall`, `fwClrSetupEnd`, `fwIrqAck`). When a set and a clear of the same flag fall in one cycle, the set wins.
- R14: After a STALL, the next 8-byte SETUP is accepted normally.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| evValid | input | 1 | One-cycle strobe: a decoded transaction is present |
| evTok | input | 2 | Token kind: 00 OUT, 01 IN, 10 SETUP, 11 ignored |
| evLen | input | LEN_W | Received payload length in bytes |
| evData1 | input | 1 | Received data packet carried DATA1 |
| txAck | input | 1 | Host acknowledged the IN data packet just sent |
| fwServiced | input | 1 | Firmware has unloaded the received packet |
| fwInRdy | input | 1 | Firmware has loaded an IN packet |
| fwTxLen | input | LEN_W | Length of the packet loaded with fwInRdy |
| fwDataEnd | input | 1 | Marks the final packet of the data stage |
| fwStall | input | 1 | Stall the next IN or OUT token |
| fwClrStall | input | 1 | Clear stallSent |
| fwClrSetupEnd | input | 1 | Clear setupEnd |
| fwIrqAck | input | 1 | Clear all pending interrupt events |
| hsValid | output | 1 | Handshake decision present (one cycle) |
| hsCode | output | 2 | 0 none, 1 ACK, 2 NAK, 3 STALL |
| outPktRdy | output | 1 | Received packet waiting for firmware |
| inPktRdy | output | 1 | Loaded IN packet waiting to be sent |
| stallSent | output | 1 | A STALL has been issued |
| setupEnd | output | 1 | Transmit sequence was cut short by SETUP or OUT |
| txMode | output | 1 | Endpoint is in transmit mode |
| phase | output | 3 | 0 idle, 1 IN data, 2 OUT data, 3 IN status, 4 OUT status |
| irq | output | 1 | OR of pending events |

## Verification
Two collisions are worth attention. The first is a firmware clear and a hardware set of the same flag in the same cycle. The bench drives an accepted SETUP in the same cycle as `fwServiced` and `fwIrqAck`. It expects `outPktRdy` and `irq` to remain set, because a fresh event must never be lost to a stale acknowledge. The second is a full-size last packet against a short one. Packets of 64 and 10 bytes are acknowledged in turn: transmit mode must survive the first and end on the second, where the phase moves on to the status stage.

// File: rtl/ep0Pkg.sv
package ep0Pkg;

  typedef enum logic [1:0] {
    TOK_OUT   = 2'b00,
    TOK_IN    = 2'b01,
    TOK_SETUP = 2'b10,
    TOK_NONE  = 2'b11
  } tokE;

  typedef enum logic [1:0] {
    HS_NONE  = 2'd0,
    HS_ACK   = 2'd1,
    HS_NAK   = 2'd2,
    HS_STALL = 2'd3
  } hsE;

  typedef enum logic [2:0] {
    PH_IDLE  = 3'd0,
    PH_DIN   = 3'd1,
    PH_DOUT  = 3'd2,
    PH_STOUT = 3'd3,
    PH_STIN  = 3'd4
  } phaseE;

  // strobes from control to datapath
  typedef struct packed {
    logic setOutRdy;
    logic clrInRdy;
    logic setStall;
    logic setSetupEnd;
    logic pendRx;
    logic pendTx;
  } ctlStrobeT;

  // comparisons and flag state from datapath to control
  typedef struct packed {
    logic setupLenOk;
    logic rxOversize;
    logic rxEmpty;
    logic txShort;
    logic outRdy;
    logic inRdy;
  } dpStatusT;

endpackage

// File: rtl/ep0Data.sv
module ep0Data
  import ep0Pkg::*;
#(
  parameter int MAX_PKT   = 64,
  parameter int LEN_W     = 8,
  parameter int SETUP_LEN = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [LEN_W-1:0] evLen,
  input  logic [LEN_W-1:0] fwTxLen,
  input  logic             fwInRdy,
  input  logic             fwServiced,
  input  logic             fwClrStall,
  input  logic             fwClrSetupEnd,
  input  logic             fwIrqAck,
  input  ctlStrobeT        ctl,
  output dpStatusT         dpSt,
  output logic             outPktRdy,
  output logic             inPktRdy,
  output logic             stallSent,
  output logic             setupEnd,
  output logic             irq
);

  localparam int NEV = 3;
  localparam logic [LEN_W-1:0] MAX_L   = LEN_W'(MAX_PKT);
  localparam logic [LEN_W-1:0] SETUP_L = LEN_W'(SETUP_LEN);

  logic [LEN_W-1:0] txLenQ;
  logic [NEV-1:0]   pendSet;
  logic [NEV-1:0]   pendQ;

  always_comb begin
    dpSt.setupLenOk = (evLen == SETUP_L);
    dpSt.rxOversize = (evLen > MAX_L);
    dpSt.rxEmpty    = (evLen == '0);
    dpSt.txShort    = (txLenQ < MAX_L);
    dpSt.outRdy     = outPktRdy;
    dpSt.inRdy      = inPktRdy;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      txLenQ    <= '0;
      outPktRdy <= 1'b0;
      inPktRdy  <= 1'b0;
      stallSent <= 1'b0;
      setupEnd  <= 1'b0;
    end else begin
      if (fwInRdy) txLenQ <= fwTxLen;
      // a set always beats a clear in the same cycle
      if (ctl.setOutRdy)     outPktRdy <= 1'b1;
      else if (fwServiced)   outPktRdy <= 1'b0;
      if (fwInRdy)           inPktRdy  <= 1'b1;
      else if (ctl.clrInRdy) inPktRdy  <= 1'b0;
      if (ctl.setStall)      stallSent <= 1'b1;
      else if (fwClrStall)   stallSent <= 1'b0;
      if (ctl.setSetupEnd)   setupEnd  <= 1'b1;
      else if (fwClrSetupEnd) setupEnd <= 1'b0;
    end
  end

  assign pendSet = {ctl.setStall, ctl.pendTx, ctl.pendRx};

  for (genvar i = 0; i < NEV; i++) begin : g_pend
    always_ff @(posedge clk) begin
      if (!rstN)           pendQ[i] <= 1'b0;
      else if (pendSet[i]) pendQ[i] <= 1'b1;
      else if (fwIrqAck)   pendQ[i] <= 1'b0;
    end
  end

  assign irq = |pendQ;

  // R3
  out_rdy_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    outPktRdy && !fwServiced |=> outPktRdy);

  // R5
  in_rdy_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    ctl.clrInRdy && !fwInRdy |=> !inPktRdy && irq);

  // R13
  stall_sticky_chk: assert property (@(posedge clk) disable iff (!rstN)
    stallSent && !fwClrStall |=> stallSent);

  // R13
  irq_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    !irq && pendSet == '0 |=> !irq);

endmodule

// File: rtl/ep0Ctrl.sv
module ep0Ctrl
  import ep0Pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       evValid,
  input  logic [1:0] evTok,
  input  logic       evData1,
  input  logic       txAck,
  input  logic       fwServiced,
  input  logic       fwInRdy,
  input  logic       fwDataEnd,
  input  logic       fwStall,
  input  dpStatusT   dpSt,
  output ctlStrobeT  ctl,
  output logic       hsValid,
  output logic [1:0] hsCode,
  output logic [2:0] phase,
  output logic       txMode
);

  phaseE phQ, phNext;
  hsE    hsQ, hsNext;
  logic  hsVQ, hsVNext;
  logic  txModeQ, txNext;
  logic  armQ, armNext;    // firmware-forced stall pending
  logic  lastQ, lastNext;  // final IN packet loaded
  logic  doStall;

  always_comb begin
    phNext  = phQ;
    txNext  = txModeQ;
    armNext = armQ;
    lastNext = lastQ;
    hsVNext = 1'b0;
    hsNext  = HS_NONE;
    ctl     = '0;
    doStall = 1'b0;

    if (fwStall) armNext = 1'b1;
    if (fwInRdy && fwDataEnd) lastNext = 1'b1;
    if (fwServiced && fwDataEnd && (phQ == PH_IDLE || phQ == PH_DOUT))
      phNext = PH_STIN;

    if (txAck && dpSt.inRdy && phQ == PH_DIN) begin
      ctl.clrInRdy = 1'b1;
      ctl.pendTx   = 1'b1;
      if (dpSt.txShort) txNext = 1'b0;
      if (lastQ) begin
        phNext   = PH_STOUT;
        lastNext = 1'b0;
      end
    end

    if (evValid) begin
      case (tokE'(evTok))
        TOK_SETUP: begin
          if (dpSt.setupLenOk) begin
            hsVNext         = 1'b1;
            hsNext          = HS_ACK;
            ctl.setOutRdy   = 1'b1;
            ctl.pendRx      = 1'b1;
            ctl.setSetupEnd = txModeQ;
            txNext   = 1'b0;
            phNext   = PH_IDLE;
            armNext  = 1'b0;
            lastNext = 1'b0;
          end
        end
        TOK_OUT: begin
          ctl.setSetupEnd = txModeQ;
          txNext  = 1'b0;
          hsVNext = 1'b1;
          if (armQ || dpSt.rxOversize || phQ == PH_STIN ||
              (phQ == PH_STOUT && evData1 && !dpSt.rxEmpty)) begin
            doStall = 1'b1;
          end else if (phQ == PH_STOUT || phQ == PH_DIN) begin
            hsNext   = HS_ACK;
            phNext   = PH_IDLE;
            lastNext = 1'b0;
          end else if (dpSt.outRdy) begin
            hsNext = HS_NAK;
          end else begin
            hsNext        = HS_ACK;
            ctl.setOutRdy = 1'b1;
            ctl.pendRx    = 1'b1;
            phNext        = PH_DOUT;
          end
        end
        TOK_IN: begin
          hsVNext = 1'b1;
          if (armQ || phQ == PH_STOUT) begin
            doStall = 1'b1;
          end else if (phQ == PH_STIN || phQ == PH_DOUT) begin
            hsNext     = HS_ACK;
            ctl.pendTx = 1'b1;
            phNext     = PH_IDLE;
          end else begin
            txNext = 1'b1;
            phNext = PH_DIN;
            hsNext = dpSt.inRdy ? HS_ACK : HS_NAK;
          end
        end
        default: ;
      endcase
    end

    if (doStall) begin
      hsNext       = HS_STALL;
      ctl.setStall = 1'b1;
      phNext   = PH_IDLE;
      txNext   = 1'b0;
      armNext  = 1'b0;
      lastNext = 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      phQ     <= PH_IDLE;
      hsQ     <= HS_NONE;
      hsVQ    <= 1'b0;
      txModeQ <= 1'b0;
      armQ    <= 1'b0;
      lastQ   <= 1'b0;
    end else begin
      phQ     <= phNext;
      hsQ     <= hsNext;
      hsVQ    <= hsVNext;
      txModeQ <= txNext;
      armQ    <= armNext;
      lastQ   <= lastNext;
    end
  end

  assign hsValid = hsVQ;
  assign hsCode  = hsQ;
  assign phase   = phQ;
  assign txMode  = txModeQ;

  // R2
  setup_reject_chk: assert property (@(posedge clk) disable iff (!rstN)
    evValid && evTok == TOK_SETUP && !dpSt.setupLenOk |=> !hsValid);

  // R4
  in_nak_chk: assert property (@(posedge clk) disable iff (!rstN)
    evValid && evTok == TOK_IN && !dpSt.inRdy && !armQ &&
    (phQ == PH_IDLE || phQ == PH_DIN) |=> hsValid && hsCode == HS_NAK);

  // R12
  stall_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    hsValid && hsCode == HS_STALL |-> phase == PH_IDLE && !txMode);

  // R7
  setup_ends_tx_chk: assert property (@(posedge clk) disable iff (!rstN)
    evValid && evTok == TOK_SETUP && dpSt.setupLenOk |=> !txMode);

endmodule

// File: rtl/usbEp0Seq.sv
module usbEp0Seq
  import ep0Pkg::*;
#(
  parameter  int MAX_PKT = 64,
  localparam int LEN_W   = $clog2(MAX_PKT) + 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             evValid,
  input  logic [1:0]       evTok,
  input  logic [LEN_W-1:0] evLen,
  input  logic             evData1,
  input  logic             txAck,
  input  logic             fwServiced,
  input  logic             fwInRdy,
  input  logic [LEN_W-1:0] fwTxLen,
  input  logic             fwDataEnd,
  input  logic             fwStall,
  input  logic             fwClrStall,
  input  logic             fwClrSetupEnd,
  input  logic             fwIrqAck,
  output logic             hsValid,
  output logic [1:0]       hsCode,
  output logic             outPktRdy,
  output logic             inPktRdy,
  output logic             stallSent,
  output logic             setupEnd,
  output logic             txMode,
  output logic [2:0]       phase,
  output logic             irq
);

  ctlStrobeT ctl;
  dpStatusT  dpSt;

  ep0Ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .evValid(evValid), .evTok(evTok),
    .evData1(evData1), .txAck(txAck), .fwServiced(fwServiced),
    .fwInRdy(fwInRdy), .fwDataEnd(fwDataEnd), .fwStall(fwStall),
    .dpSt(dpSt), .ctl(ctl), .hsValid(hsValid), .hsCode(hsCode),
    .phase(phase), .txMode(txMode)
  );

  ep0Data #(.MAX_PKT(MAX_PKT), .LEN_W(LEN_W), .SETUP_LEN(8)) u_data (
    .clk(clk), .rstN(rstN), .evLen(evLen), .fwTxLen(fwTxLen),
    .fwInRdy(fwInRdy), .fwServiced(fwServiced), .fwClrStall(fwClrStall),
    .fwClrSetupEnd(fwClrSetupEnd), .fwIrqAck(fwIrqAck), .ctl(ctl),
    .dpSt(dpSt), .outPktRdy(outPktRdy), .inPktRdy(inPktRdy),
    .stallSent(stallSent), .setupEnd(setupEnd), .irq(irq)
  );

endmodule

// File: tb/usbEp0Seq_tb.sv
`timescale 1ns/1ps
module usbEp0Seq_tb;

  localparam int MAXP  = 64;
  localparam int LEN_W = $clog2(MAXP) + 2;
  localparam int T_OUT = 0, T_IN = 1, T_SETUP = 2;
  localparam int H_NONE = 0, H_ACK = 1, H_NAK = 2, H_STALL = 3;

  logic clk = 1'b0;
  logic rstN;
  logic evValid, evData1, txAck, fwServiced, fwInRdy, fwDataEnd, fwStall;
  logic fwClrStall, fwClrSetupEnd, fwIrqAck;
  logic [1:0] evTok;
  logic [LEN_W-1:0] evLen, fwTxLen;
  logic hsValid, outPktRdy, inPktRdy, stallSent, setupEnd, txMode, irq;
  logic [1:0] hsCode;
  logic [2:0] phase;

  int nChk = 0;
  int nErr = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  usbEp0Seq #(.MAX_PKT(MAXP)) u_dut (
    .clk(clk), .rstN(rstN), .evValid(evValid), .evTok(evTok), .evLen(evLen),
    .evData1(evData1), .txAck(txAck), .fwServiced(fwServiced),
    .fwInRdy(fwInRdy), .fwTxLen(fwTxLen), .fwDataEnd(fwDataEnd),
    .fwStall(fwStall), .fwClrStall(fwClrStall), .fwClrSetupEnd(fwClrSetupEnd),
    .fwIrqAck(fwIrqAck), .hsValid(hsValid), .hsCode(hsCode),
    .outPktRdy(outPktRdy), .inPktRdy(inPktRdy), .stallSent(stallSent),
    .setupEnd(setupEnd), .txMode(txMode), .phase(phase), .irq(irq)
  );

  function automatic int expSetupHs(int len);
    return (len == 8) ? H_ACK : H_NONE;
  endfunction

  function automatic int expOutHs(int len, bit rdy);
    if (len > MAXP) return H_STALL;
    return rdy ? H_NAK : H_ACK;
  endfunction

  task automatic clearIn();
    evValid = 0; evTok = 2'b11; evLen = '0; evData1 = 0; txAck = 0;
    fwServiced = 0; fwInRdy = 0; fwTxLen = '0; fwDataEnd = 0; fwStall = 0;
    fwClrStall = 0; fwClrSetupEnd = 0; fwIrqAck = 0;
  endtask

  task automatic tick();
    @(negedge clk);
    clearIn();
  endtask

  task automatic chk(input string req, input int act, input int exp);
    nChk++;
    if (act != exp) begin
      nErr++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic sendEv(input int tok, input int len, input bit d1);
    evValid = 1; evTok = tok[1:0]; evLen = len[LEN_W-1:0]; evData1 = d1;
    tick();
  endtask

  task automatic hsChk(input string req, input int exp);
    chk(req, hsValid ? int'(hsCode) : H_NONE, exp);
  endtask

  task automatic loadIn(input int len, input bit last);
    fwInRdy = 1; fwTxLen = len[LEN_W-1:0]; fwDataEnd = last;
    tick();
  endtask

  task automatic cleanUp();
    fwServiced = 1; fwClrStall = 1; fwClrSetupEnd = 1; fwIrqAck = 1;
    tick();
  endtask

  initial begin
    #(4 * 150000);
    if (!done) begin
      nErr++;
      $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
      $display("Simulation finished: %0d checks, %0d errors", nChk, nErr);
      $finish;
    end
  end

  initial begin
    clearIn();
    rstN = 0;
    repeat (3) @(negedge clk);
    rstN = 1;
    // R1 reset state
    chk("R1 flags", {outPktRdy, inPktRdy, stallSent, setupEnd, txMode, irq}, 0);
    chk("R1 phase", phase, 0);
    chk("R1 hsValid", hsValid, 0);

    // R2 setup length filter
    sendEv(T_SETUP, 7, 0);
    hsChk("R2 reject hs", H_NONE);
    chk("R2 reject flags", {outPktRdy, irq}, 0);
    sendEv(T_SETUP, 8, 0);
    hsChk("R2 accept hs", H_ACK);
    chk("R2 accept flags", {outPktRdy, irq}, 2'b11);

    // R3 hold and NAK
    sendEv(T_OUT, 0, 0);
    hsChk("R3 nak", H_NAK);
    tick();
    chk("R3 held", outPktRdy, 1);
    fwIrqAck = 1; tick();
    chk("R13 irq ack", irq, 0);
    fwServiced = 1; tick();
    chk("R3 serviced", outPktRdy, 0);

    // R4 / R6 NAK enters transmit mode
    sendEv(T_IN, 0, 0);
    hsChk("R4 nak", H_NAK);
    chk("R4 no irq", irq, 0);
    chk("R6 txMode on", txMode, 1);
    chk("R6 phase din", phase, 1);

    // full-size packet keeps transmit mode
    loadIn(64, 0);
    chk("R4 inRdy", inPktRdy, 1);
    sendEv(T_IN, 0, 0);
    hsChk("R4 ack", H_ACK);
    txAck = 1; tick();
    chk("R5 cleared", inPktRdy, 0);
    chk("R5 irq", irq, 1);
    chk("R6 full keeps", txMode, 1);
    fwIrqAck = 1; tick();

    // short last packet
    loadIn(10, 1);
    sendEv(T_IN, 0, 0);
    hsChk("R4 ack2", H_ACK);
    txAck = 1; tick();
    chk("R6 short ends", txMode, 0);
    chk("R8 phase stout", phase, 3);
    fwIrqAck = 1; tick();
    sendEv(T_IN, 0, 0);
    hsChk("R8 stall", H_STALL);
    chk("R12 stallSent", stallSent, 1);
    chk("R12 irq", irq, 1);
    chk("R12 phase idle", phase, 0);
    tick();
    chk("R13 stall sticky", stallSent, 1);
    fwClrStall = 1; tick();
    chk("R13 stall clr", stallSent, 0);
    fwIrqAck = 1; tick();

    // R14 then R7
    sendEv(T_SETUP, 8, 0);
    hsChk("R14 setup after stall", H_ACK);
    fwServiced = 1; tick();
    sendEv(T_IN, 0, 0);
    chk("R7 tx on", txMode, 1);
    sendEv(T_SETUP, 8, 0);
    chk("R7 setupEnd", setupEnd, 1);
    chk("R7 tx off", txMode, 0);
    tick(); tick();
    chk("R13 setupEnd sticky", setupEnd, 1);
    fwClrSetupEnd = 1; tick();
    chk("R13 setupEnd clr", setupEnd, 0);
    fwServiced = 1; fwIrqAck = 1; tick();

    // R11 status phase of IN transfer
    loadIn(5, 1);
    sendEv(T_IN, 0, 0);
    txAck = 1; tick();
    chk("R11 phase stout", phase, 3);
    sendEv(T_OUT, 3, 1);
    hsChk("R11 nonzero stall", H_STALL);
    cleanUp();
    sendEv(T_SETUP, 8, 0);
    fwServiced = 1; tick();
    loadIn(5, 1);
    sendEv(T_IN, 0, 0);
    txAck = 1; tick();
    sendEv(T_OUT, 0, 1);
    hsChk("R11 zlp ack", H_ACK);
    chk("R11 idle", phase, 0);
    cleanUp();

    // R9 OUT after data end
    sendEv(T_SETUP, 8, 0);
    fwServiced = 1; tick();
    sendEv(T_OUT, 20, 1);
    hsChk("R9 data ack", H_ACK);
    chk("R9 phase dout", phase, 2);
    fwServiced = 1; fwDataEnd = 1; tick();
    chk("R9 phase stin", phase, 4);
    sendEv(T_OUT, 0, 1);
    hsChk("R9 stall", H_STALL);
    cleanUp();

    // R10 size boundary
    sendEv(T_OUT, 65, 0);
    hsChk("R10 oversize", H_STALL);
    chk("R10 no rdy", outPktRdy, 0);
    cleanUp();
    sendEv(T_OUT, 64, 0);
    hsChk("R10 max ok", H_ACK);
    cleanUp();

    // R12 forced stall
    sendEv(T_SETUP, 8, 0);
    cleanUp();
    fwStall = 1; tick();
    chk("R12 arm silent", hsValid, 0);
    sendEv(T_IN, 0, 0);
    hsChk("R12 forced", H_STALL);
    chk("R12 forced flag", stallSent, 1);
    cleanUp();

    // R13 set beats clear in the same cycle
    sendEv(T_SETUP, 8, 0);
    fwServiced = 1; fwIrqAck = 1;
    sendEv(T_SETUP, 8, 0);
    chk("R13 rdy set wins", outPktRdy, 1);
    chk("R13 irq set wins", irq, 1);
    cleanUp();

    // random mix of setup lengths and OUT sizes
    void'($urandom(32'h5EED));
    for (int i = 0; i < 40; i++) begin
      int sl, ol;
      sl = $urandom_range(0, 15);
      sendEv(T_SETUP, sl, 0);
      hsChk("R2 rand setup", expSetupHs(sl));
      cleanUp();
      ol = $urandom_range(0, 100);
      sendEv(T_OUT, ol, $urandom_range(0, 1));
      hsChk("R10 rand out", expOutHs(ol, 1'b0));
      chk("R12 rand stall flag", stallSent, (ol > MAXP) ? 1 : 0);
      cleanUp();
    end

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", nChk, nErr);
    $finish;
  end

endmodule